// File: doc/BRIEF.md
# USB Device OUT/SETUP Transaction Engine

This block is the device-side decision logic for full-speed OUT and SETUP transactions. Upstream logic hands it decoded token packets (PID, device address, endpoint number) and decoded data packets (PID, PID-check error, bit-stuff error, CRC status, byte count). The block walks each transaction through a small state machine. It consults a per-endpoint table that holds enable, isochronous type, stall, data toggle, buffer-busy, setup, overflow, byte count and data pointer. From these it picks one of four handshakes, emits a store strobe when the payload should be kept, rewrites the endpoint entry and raises sticky interrupt flags.

The table is indexed by `{direction, endpoint}`, where direction 0 is the output (host-to-device) entry and direction 1 is the input entry. A configuration port writes whole entries, and a combinational read port returns any entry. The interrupt flags are write-one-to-clear on a separate port.

Entry layout, MSB first: en, iso, stall, tog, busy, setup, ovf, cnt[6:0], ptr[7:0] (22 bits). PID codes: OUT 4'b0001, SETUP 4'b1101, DATA0 4'b0011, DATA1 4'b1011. Interrupt bits: 0 setup, 1 stall, 2 overflow, 3 transfer done. Handshake codes: 0 none, 1 ACK, 2 NAK, 3 STALL.

Top module: `usbo_out_txn`

## Requirements
- R1: After reset every table entry reads zero, `irq_flags` is zero, and `hs_valid` and `store_valid` are low.
- R2: A token whose address differs from `dev_addr`, or whose PID is neither OUT nor SETUP, is ignored. No handshake follows, no store occurs and no entry changes.
- R3: An OUT token to an output entry with en=0 returns the engine to idle. The following data packet gets no handshake and no entry changes.
- R4: A data packet with `dat_pid_err` set, or with a PID other than DATA0/DATA1, produces no handshake, no store and no entry change.
- R5: A data packet with a bit-stuff error or a bad CRC produces no handshake, no store and no entry change. This applies to every endpoint type and every token type.
- R6: On an OUT to a stalled entry the data is not stored. A non-isochronous entry returns STALL (code 3) and sets interrupt bit 1. An isochronous entry returns nothing and sets no flag.
- R7: On a non-isochronous entry, a data PID whose toggle (DATA1 means 1) differs from tog returns NAK (code 2) and leaves the entry unchanged. An isochronous entry accepts both DATA0 and DATA1.
- R8: When busy=1 on a non-stalled entry that passes the toggle check, the data is discarded. The block sets ovf and interrupt bit 2, and returns NAK if the entry is non-isochronous or nothing if it is isochronous.
- R9: A good OUT to a free entry raises `store_valid` with the entry's ptr and `dat_len`. It sets busy, writes cnt=`dat_len` and sets interrupt bit 3. A non-isochronous entry also inverts tog and returns ACK (code 1). An isochronous entry keeps tog and returns nothing.
- R10: A good SETUP (any enable state) is stored and returns ACK. The output entry gets tog=1, busy=1, setup=1, ovf=0, stall=0 and cnt=`dat_len`. The input entry of the same number gets the same flags with cnt=0. Interrupt bit 0 is set.
- R11: `hs_valid` is a single-cycle pulse that comes one clock after the data packet is sampled. It is raised only for ACK, NAK or STALL, and `hs_code` carries the code.
- R12: Interrupt flags are sticky. A one on `irq_clr` clears the bit at the next edge, but a bit that is being set in the same cycle stays set.
- R13: A `cfg_we` pulse writes `cfg_data` into entry `{cfg_dir, cfg_ep}`, and `rd_data` returns entry `{rd_dir, rd_ep}` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Assigned device address |
| tok_valid | input | 1 | Token packet strobe |
| tok_pid | input | 4 | Token PID |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 2 | Token endpoint number |
| dat_valid | input | 1 | Data packet end strobe |
| dat_pid | input | 4 | Data packet PID |
| dat_pid_err | input | 1 | PID check-field error |
| dat_stuff_err | input | 1 | Bit-stuffing error |
| dat_crc_ok | input | 1 | Data CRC good |
| dat_len | input | 7 | Received byte count |
| cfg_we | input | 1 | Entry write strobe |
| cfg_dir | input | 1 | Entry direction for write |
| cfg_ep | input | 2 | Entry endpoint for write |
| cfg_data | input | 22 | Entry write value |
| rd_dir | input | 1 | Entry direction for read |
| rd_ep | input | 2 | Entry endpoint for read |
| rd_data | output | 22 | Entry read value |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | Handshake code |
| store_valid | output | 1 | Payload keep strobe |
| store_ptr | output | 8 | Data pointer of the stored packet |
| store_len | output | 7 | Byte count of the stored packet |
| irq_clr | input | 4 | Write-one-to-clear for flags |
| irq_flags | output | 4 | Sticky interrupt flags |

## Verification
An interrupt can be raised by a finishing transaction in the same cycle that software clears flags through `irq_clr`. The bench provokes this by driving `irq_clr` with all ones for exactly the clock edge on which the handshake and the table update land. It does this both in directed SETUP, stall and overflow cases and at random during the constrained-random run. The check expects the newly raised bit to survive while every other bit is cleared, which the bench model computes as the set mask alone.

// File: rtl/usbo_pkg.sv
package usbo_pkg;
  localparam int EPS    = 4;
  localparam int EPW    = $clog2(EPS);
  localparam int NENT   = 2 * EPS;
  localparam int IDXW   = EPW + 1;
  localparam int MAXPKT = 64;
  localparam int LENW   = $clog2(MAXPKT + 1);
  localparam int PTRW   = 8;
  localparam int ADRW   = 7;
  localparam int NIRQ   = 4;

  localparam int IRQ_SETUP = 0;
  localparam int IRQ_STALL = 1;
  localparam int IRQ_OVF   = 2;
  localparam int IRQ_DONE  = 3;

  localparam logic [3:0] PID_OUT   = 4'b0001;
  localparam logic [3:0] PID_SETUP = 4'b1101;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef struct packed {
    logic            en;
    logic            iso;
    logic            stall;
    logic            tog;
    logic            busy;
    logic            setup;
    logic            ovf;
    logic [LENW-1:0] cnt;
    logic [PTRW-1:0] ptr;
  } ep_t;

  localparam int EPB = $bits(ep_t);

  function automatic logic pid_is_data(input logic [3:0] pid);
    return (pid == PID_DATA0) || (pid == PID_DATA1);
  endfunction

  function automatic logic pid_toggle(input logic [3:0] pid);
    return pid[3];
  endfunction

  function automatic logic frame_good(input logic stuff_err, input logic crc_ok);
    return !stuff_err && crc_ok;
  endfunction

  function automatic ep_t after_setup(input ep_t e, input logic [LENW-1:0] len);
    ep_t r;
    r       = e;
    r.stall = 1'b0;
    r.tog   = 1'b1;
    r.busy  = 1'b1;
    r.setup = 1'b1;
    r.ovf   = 1'b0;
    r.cnt   = len;
    return r;
  endfunction
endpackage

// File: rtl/usbo_ep_table.sv
module usbo_ep_table
  import usbo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  ep_t             cfg_d,
  input  logic [IDXW-1:0] rd_idx,
  output ep_t             rd_q,
  input  logic [EPW-1:0]  eng_ep,
  output ep_t             eng_out_q,
  output ep_t             eng_in_q,
  input  logic            upd_out_we,
  input  ep_t             upd_out_d,
  input  logic            upd_in_we,
  input  ep_t             upd_in_d
);
  ep_t ent [NENT];

  logic [NENT-1:0] hit_cfg, hit_out, hit_in;

  for (genvar g = 0; g < NENT; g++) begin : g_hit
    assign hit_cfg[g] = cfg_we && (cfg_idx == IDXW'(g));
    assign hit_out[g] = upd_out_we && ({1'b0, eng_ep} == IDXW'(g));
    assign hit_in[g]  = upd_in_we  && ({1'b1, eng_ep} == IDXW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) ent[i] <= '0;
    end else begin
      for (int i = 0; i < NENT; i++) begin
        if (hit_out[i])      ent[i] <= upd_out_d;
        else if (hit_in[i])  ent[i] <= upd_in_d;
        else if (hit_cfg[i]) ent[i] <= cfg_d;
      end
    end
  end

  assign rd_q      = ent[rd_idx];
  assign eng_out_q = ent[{1'b0, eng_ep}];
  assign eng_in_q  = ent[{1'b1, eng_ep}];

  // R13: a lone configuration write lands in the addressed entry
  a_r13_cfg_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !upd_out_we && !upd_in_we) |=> (ent[$past(cfg_idx)] == $past(cfg_d)));
endmodule

// File: rtl/usbo_decide.sv
module usbo_decide
  import usbo_pkg::*;
(
  input  logic            is_setup,
  input  logic            good,
  input  logic            dtog,
  input  logic [LENW-1:0] len,
  input  ep_t             out_q,
  input  ep_t             in_q,
  output hs_e             hs,
  output logic            keep,
  output logic            upd_out,
  output ep_t             out_d,
  output logic            upd_in,
  output ep_t             in_d,
  output logic [NIRQ-1:0] irq_set
);
  logic stall_hit, tog_miss, busy_hit;

  assign stall_hit = out_q.stall;
  assign tog_miss  = !out_q.iso && (dtog != out_q.tog);
  assign busy_hit  = out_q.busy;

  always_comb begin
    hs      = HS_NONE;
    keep    = 1'b0;
    upd_out = 1'b0;
    upd_in  = 1'b0;
    out_d   = out_q;
    in_d    = in_q;
    irq_set = '0;
    if (!good) begin
      hs = HS_NONE;
    end else if (is_setup) begin
      keep    = 1'b1;
      hs      = HS_ACK;
      upd_out = 1'b1;
      upd_in  = 1'b1;
      out_d   = after_setup(out_q, len);
      in_d    = after_setup(in_q, '0);
      irq_set[IRQ_SETUP] = 1'b1;
    end else if (stall_hit) begin
      if (!out_q.iso) begin
        hs = HS_STALL;
        irq_set[IRQ_STALL] = 1'b1;
      end
    end else if (tog_miss) begin
      hs = HS_NAK;
    end else if (busy_hit) begin
      upd_out   = 1'b1;
      out_d.ovf = 1'b1;
      irq_set[IRQ_OVF] = 1'b1;
      if (!out_q.iso) hs = HS_NAK;
    end else begin
      keep       = 1'b1;
      upd_out    = 1'b1;
      out_d.busy = 1'b1;
      out_d.cnt  = len;
      irq_set[IRQ_DONE] = 1'b1;
      if (!out_q.iso) begin
        out_d.tog = !out_q.tog;
        hs        = HS_ACK;
      end
    end
  end
endmodule

// File: rtl/usbo_irq.sv
module usbo_irq
  import usbo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_i,
  input  logic [NIRQ-1:0] clr_i,
  output logic [NIRQ-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= (flags_o & ~clr_i) | set_i;
  end

  // R12: a bit raised in a cycle is present next cycle, clear or not
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  // R12: a cleared bit with no concurrent set is low next cycle
  a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/usbo_out_txn.sv
module usbo_out_txn
  import usbo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADRW-1:0] dev_addr,
  input  logic            tok_valid,
  input  logic [3:0]      tok_pid,
  input  logic [ADRW-1:0] tok_addr,
  input  logic [EPW-1:0]  tok_ep,
  input  logic            dat_valid,
  input  logic [3:0]      dat_pid,
  input  logic            dat_pid_err,
  input  logic            dat_stuff_err,
  input  logic            dat_crc_ok,
  input  logic [LENW-1:0] dat_len,
  input  logic            cfg_we,
  input  logic            cfg_dir,
  input  logic [EPW-1:0]  cfg_ep,
  input  logic [EPB-1:0]  cfg_data,
  input  logic            rd_dir,
  input  logic [EPW-1:0]  rd_ep,
  output logic [EPB-1:0]  rd_data,
  output logic            hs_valid,
  output logic [1:0]      hs_code,
  output logic            store_valid,
  output logic [PTRW-1:0] store_ptr,
  output logic [LENW-1:0] store_len,
  input  logic [NIRQ-1:0] irq_clr,
  output logic [NIRQ-1:0] irq_flags
);
  typedef enum logic [2:0] {S_IDLE, S_CFG, S_PTR, S_WAIT, S_DEC} st_e;

  st_e             st;
  logic [EPW-1:0]  ep_q;
  logic            setup_q;
  logic [PTRW-1:0] ptr_q;
  logic            dtog_q, good_q;
  logic [LENW-1:0] len_q;

  ep_t eng_out_q, eng_in_q, upd_out_d, upd_in_d, rd_q;
  logic upd_out_raw, upd_in_raw, keep;
  hs_e  hs_pick;
  logic [NIRQ-1:0] set_raw, irq_set;

  // named events
  logic tok_hit, ep_dead, data_bad, data_take, dec_fire;

  assign tok_hit   = (st == S_IDLE) && tok_valid && (tok_addr == dev_addr) &&
                     ((tok_pid == PID_OUT) || (tok_pid == PID_SETUP));
  assign ep_dead   = (st == S_CFG) && !setup_q && !eng_out_q.en;
  assign data_bad  = (st == S_WAIT) && !tok_valid && dat_valid &&
                     (dat_pid_err || !pid_is_data(dat_pid));
  assign data_take = (st == S_WAIT) && !tok_valid && dat_valid && !data_bad;
  assign dec_fire  = (st == S_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ep_q    <= '0;
      setup_q <= 1'b0;
      ptr_q   <= '0;
      dtog_q  <= 1'b0;
      good_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (tok_hit) begin
          ep_q    <= tok_ep;
          setup_q <= (tok_pid == PID_SETUP);
          st      <= S_CFG;
        end
        S_CFG:  st <= ep_dead ? S_IDLE : S_PTR;
        S_PTR: begin
          ptr_q <= eng_out_q.ptr;
          st    <= S_WAIT;
        end
        S_WAIT: begin
          if (tok_valid || data_bad) st <= S_IDLE;
          else if (data_take) begin
            dtog_q <= pid_toggle(dat_pid);
            good_q <= frame_good(dat_stuff_err, dat_crc_ok);
            len_q  <= dat_len;
            st     <= S_DEC;
          end
        end
        S_DEC:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  usbo_decide u_decide (
    .is_setup (setup_q),
    .good     (good_q),
    .dtog     (dtog_q),
    .len      (len_q),
    .out_q    (eng_out_q),
    .in_q     (eng_in_q),
    .hs       (hs_pick),
    .keep     (keep),
    .upd_out  (upd_out_raw),
    .out_d    (upd_out_d),
    .upd_in   (upd_in_raw),
    .in_d     (upd_in_d),
    .irq_set  (set_raw)
  );

  assign irq_set = dec_fire ? set_raw : '0;

  usbo_ep_table u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    ({cfg_dir, cfg_ep}),
    .cfg_d      (ep_t'(cfg_data)),
    .rd_idx     ({rd_dir, rd_ep}),
    .rd_q       (rd_q),
    .eng_ep     (ep_q),
    .eng_out_q  (eng_out_q),
    .eng_in_q   (eng_in_q),
    .upd_out_we (dec_fire && upd_out_raw),
    .upd_out_d  (upd_out_d),
    .upd_in_we  (dec_fire && upd_in_raw),
    .upd_in_d   (upd_in_d)
  );

  assign rd_data = rd_q;

  usbo_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (irq_set),
    .clr_i   (irq_clr),
    .flags_o (irq_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_valid    <= 1'b0;
      hs_code     <= HS_NONE;
      store_valid <= 1'b0;
      store_ptr   <= '0;
      store_len   <= '0;
    end else begin
      hs_valid    <= dec_fire && (hs_pick != HS_NONE);
      hs_code     <= dec_fire ? hs_pick : HS_NONE;
      store_valid <= dec_fire && keep;
      store_ptr   <= ptr_q;
      store_len   <= len_q;
    end
  end

  // R11: handshake strobe lasts one cycle
  a_r11_hs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |=> !hs_valid);

  // R11: handshake strobe only follows a decision cycle
  a_r11_hs_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_valid) |-> $past(st == S_DEC));

  // R9: an ACK always comes with a kept payload
  a_r9_ack_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_ACK) |-> store_valid);

  // R6: a STALL handshake never keeps the payload and its flag is up
  a_r6_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_STALL) |-> (!store_valid && irq_flags[IRQ_STALL]));

  // R3: a disabled output entry sends the engine back to idle
  a_r3_dead_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ep_dead |=> (st == S_IDLE));
endmodule

// File: tb/tb_usbo_out_txn.sv
module tb_usbo_out_txn;
  import usbo_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [ADRW-1:0] dev_addr = 7'h2A;
  logic            tok_valid = 1'b0;
  logic [3:0]      tok_pid = '0;
  logic [ADRW-1:0] tok_addr = '0;
  logic [EPW-1:0]  tok_ep = '0;
  logic            dat_valid = 1'b0;
  logic [3:0]      dat_pid = '0;
  logic            dat_pid_err = 1'b0, dat_stuff_err = 1'b0, dat_crc_ok = 1'b0;
  logic [LENW-1:0] dat_len = '0;
  logic            cfg_we = 1'b0, cfg_dir = 1'b0;
  logic [EPW-1:0]  cfg_ep = '0;
  logic [EPB-1:0]  cfg_data = '0;
  logic            rd_dir = 1'b0;
  logic [EPW-1:0]  rd_ep = '0;
  logic [EPB-1:0]  rd_data;
  logic            hs_valid, store_valid;
  logic [1:0]      hs_code;
  logic [PTRW-1:0] store_ptr;
  logic [LENW-1:0] store_len;
  logic [NIRQ-1:0] irq_clr = '0, irq_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbo_out_txn dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  ep_t             m_out [EPS];
  ep_t             m_in  [EPS];
  logic [NIRQ-1:0] m_flags;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic dir, input logic [EPW-1:0] ep, input ep_t v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = dir; cfg_ep = ep; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (dir) m_in[ep] = v; else m_out[ep] = v;
  endtask

  task automatic clear_flags(input logic [NIRQ-1:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = '0;
    m_flags &= ~m;
  endtask

  // bench restatement of the decision rules
  task automatic predict(input logic [3:0] tp, input logic [ADRW-1:0] ta, input logic [EPW-1:0] te,
                         input logic [3:0] dp, input logic perr, input logic stf, input logic crc,
                         input logic [LENW-1:0] ln,
                         output logic [1:0] ehs, output bit ekeep, output logic [PTRW-1:0] eptr,
                         output logic [NIRQ-1:0] eset, output string tag);
    ep_t o;
    bit setup_tok, data1;
    o = m_out[te];
    ehs = 2'd0; ekeep = 0; eptr = o.ptr; eset = '0;
    setup_tok = (tp == 4'b1101);
    data1 = (dp == 4'b1011);
    if (ta != dev_addr || !(tp == 4'b0001 || setup_tok)) begin tag = "R2"; return; end
    if (!setup_tok && !o.en) begin tag = "R3"; return; end
    if (perr || !(dp == 4'b0011 || data1)) begin tag = "R4"; return; end
    if (stf || !crc) begin tag = "R5"; return; end
    if (setup_tok) begin
      tag = "R10"; ehs = 2'd1; ekeep = 1; eset = 4'b0001;
      m_out[te].stall = 0; m_out[te].tog = 1; m_out[te].busy = 1;
      m_out[te].setup = 1; m_out[te].ovf = 0; m_out[te].cnt = ln;
      m_in[te].stall = 0; m_in[te].tog = 1; m_in[te].busy = 1;
      m_in[te].setup = 1; m_in[te].ovf = 0; m_in[te].cnt = '0;
      return;
    end
    if (o.stall) begin
      tag = "R6";
      if (!o.iso) begin ehs = 2'd3; eset = 4'b0010; end
      return;
    end
    if (!o.iso && (data1 != o.tog)) begin tag = "R7"; ehs = 2'd2; return; end
    if (o.busy) begin
      tag = "R8"; m_out[te].ovf = 1; eset = 4'b0100;
      ehs = o.iso ? 2'd0 : 2'd2;
      return;
    end
    tag = "R9"; ekeep = 1; eset = 4'b1000;
    m_out[te].busy = 1; m_out[te].cnt = ln;
    if (!o.iso) begin m_out[te].tog = !o.tog; ehs = 2'd1; end
  endtask

  task automatic run_txn(input logic [3:0] tp, input logic [ADRW-1:0] ta, input logic [EPW-1:0] te,
                         input logic [3:0] dp, input logic perr, input logic stf, input logic crc,
                         input logic [LENW-1:0] ln, input bit clr_hit);
    logic [1:0] ehs, ghs;
    bit ekeep, gkeep;
    logic [PTRW-1:0] eptr, gptr;
    logic [LENW-1:0] glen;
    logic [NIRQ-1:0] eset;
    string tag;
    int pulses;
    predict(tp, ta, te, dp, perr, stf, crc, ln, ehs, ekeep, eptr, eset, tag);
    @(negedge clk);
    tok_valid = 1; tok_pid = tp; tok_addr = ta; tok_ep = te;
    @(negedge clk);
    tok_valid = 0;
    @(negedge clk);
    @(negedge clk);
    dat_valid = 1; dat_pid = dp; dat_pid_err = perr; dat_stuff_err = stf;
    dat_crc_ok = crc; dat_len = ln;
    pulses = 0; ghs = 2'd0; gkeep = 0; gptr = '0; glen = '0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (c == 0) begin dat_valid = 0; if (clr_hit) irq_clr = '1; end
      if (c == 1) irq_clr = '0;
      if (hs_valid) begin pulses++; ghs = hs_code; end
      if (store_valid) begin gkeep = 1; gptr = store_ptr; glen = store_len; end
    end
    m_flags = clr_hit ? eset : (m_flags | eset);
    check(tag, "handshake code", ghs, ehs);
    check("R11", "handshake pulse count", pulses, (ehs != 2'd0) ? 1 : 0);
    check(tag, "store strobe", gkeep, ekeep);
    if (ekeep) begin
      check(tag, "store ptr", gptr, eptr);
      check(tag, "store len", glen, ln);
    end
    rd_dir = 0; rd_ep = te; #1;
    check(tag, "out entry", rd_data, m_out[te]);
    rd_dir = 1; #1;
    check(tag, "in entry", rd_data, m_in[te]);
    check(clr_hit ? "R12" : tag, "irq flags", irq_flags, m_flags);
  endtask

  function automatic ep_t mk(bit en, bit iso, bit stall, bit tog, bit busy,
                             logic [PTRW-1:0] ptr);
    ep_t e;
    e = '0;
    e.en = en; e.iso = iso; e.stall = stall; e.tog = tog; e.busy = busy; e.ptr = ptr;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < EPS; i++) begin m_out[i] = '0; m_in[i] = '0; end
    m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NENT; i++) begin
      rd_dir = i[EPW]; rd_ep = i[EPW-1:0]; #1;
      check("R1", "entry after reset", rd_data, 0);
    end
    check("R1", "flags after reset", irq_flags, 0);
    check("R1", "hs after reset", hs_valid, 0);
    check("R1", "store after reset", store_valid, 0);

    // R13 write and read back
    cfg_write(1'b0, 2'd1, mk(1, 0, 0, 0, 0, 8'h40));
    rd_dir = 0; rd_ep = 2'd1; #1;
    check("R13", "cfg readback", rd_data, m_out[1]);

    // R9 normal ACK, then R8 busy NAK
    run_txn(PID_OUT, 7'h2A, 2'd1, PID_DATA0, 0, 0, 1, 7'd12, 0);
    run_txn(PID_OUT, 7'h2A, 2'd1, PID_DATA1, 0, 0, 1, 7'd5, 0);
    // R7 toggle mismatch
    cfg_write(1'b0, 2'd1, mk(1, 0, 0, 1, 0, 8'h44));
    run_txn(PID_OUT, 7'h2A, 2'd1, PID_DATA0, 0, 0, 1, 7'd3, 0);
    // R8 isochronous busy, R9 isochronous store with either PID
    cfg_write(1'b0, 2'd2, mk(1, 1, 0, 0, 1, 8'h80));
    run_txn(PID_OUT, 7'h2A, 2'd2, PID_DATA1, 0, 0, 1, 7'd64, 1);
    cfg_write(1'b0, 2'd2, mk(1, 1, 0, 0, 0, 8'h84));
    run_txn(PID_OUT, 7'h2A, 2'd2, PID_DATA1, 0, 0, 1, 7'd64, 0);
    // R6 stall on bulk and on isochronous
    cfg_write(1'b0, 2'd3, mk(1, 0, 1, 0, 0, 8'hC0));
    run_txn(PID_OUT, 7'h2A, 2'd3, PID_DATA0, 0, 0, 1, 7'd8, 1);
    cfg_write(1'b0, 2'd3, mk(1, 1, 1, 0, 0, 8'hC0));
    run_txn(PID_OUT, 7'h2A, 2'd3, PID_DATA0, 0, 0, 1, 7'd8, 0);
    // R2 address mismatch, R3 disabled, R4 bad PID, R5 CRC and stuff errors
    cfg_write(1'b0, 2'd0, mk(1, 0, 0, 0, 0, 8'h10));
    run_txn(PID_OUT, 7'h2B, 2'd0, PID_DATA0, 0, 0, 1, 7'd4, 0);
    run_txn(PID_SETUP, 7'h00, 2'd0, PID_DATA0, 0, 0, 1, 7'd8, 0);
    run_txn(PID_OUT, 7'h2A, 2'd0, 4'b0111, 0, 0, 1, 7'd4, 0);
    run_txn(PID_OUT, 7'h2A, 2'd0, PID_DATA0, 1, 0, 1, 7'd4, 0);
    run_txn(PID_OUT, 7'h2A, 2'd0, PID_DATA0, 0, 0, 0, 7'd4, 0);
    run_txn(PID_OUT, 7'h2A, 2'd0, PID_DATA0, 0, 1, 1, 7'd4, 0);
    cfg_write(1'b0, 2'd0, mk(0, 0, 0, 0, 0, 8'h10));
    run_txn(PID_OUT, 7'h2A, 2'd0, PID_DATA0, 0, 0, 1, 7'd4, 0);
    // R10 setup on a stalled, disabled entry, with a coinciding clear (R12)
    cfg_write(1'b1, 2'd0, mk(1, 0, 1, 0, 0, 8'h20));
    cfg_write(1'b0, 2'd0, mk(0, 0, 1, 0, 1, 8'h10));
    run_txn(PID_SETUP, 7'h2A, 2'd0, PID_DATA0, 0, 0, 1, 7'd8, 1);
    clear_flags('1);

    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [EPW-1:0] ep;
      logic [3:0] tp, dp;
      ep_t e;
      ep = EPW'($urandom % EPS);
      if ($urandom % 3 == 0) begin
        e = mk(($urandom % 5) != 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
               $urandom % 2, ($urandom % 4) == 0, PTRW'($urandom));
        e.setup = $urandom % 2; e.ovf = $urandom % 2; e.cnt = LENW'($urandom % 65);
        cfg_write(1'b0, ep, e);
      end
      if ($urandom % 8 == 0) begin
        e = mk($urandom % 2, 0, $urandom % 2, $urandom % 2, $urandom % 2, PTRW'($urandom));
        cfg_write(1'b1, ep, e);
      end
      case ($urandom % 6)
        0: tp = PID_SETUP;
        1: tp = ($urandom % 2) ? 4'b1001 : PID_OUT;
        default: tp = PID_OUT;
      endcase
      case ($urandom % 8)
        0: dp = 4'b0111;
        1, 2, 3: dp = PID_DATA1;
        default: dp = PID_DATA0;
      endcase
      run_txn(tp, (($urandom % 8) == 0) ? 7'h15 : 7'h2A, ep, dp,
              ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 10) != 0,
              LENW'($urandom % 65), ($urandom % 6) == 0);
      if ($urandom % 4 == 0) clear_flags(NIRQ'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule